// File: doc/BRIEF.md
# Piecewise-Linear Gamma Table Engine

This block applies a transfer curve to each of the red, green and blue channels of a pixel stream. Each curve is a table of uniformly spaced points. Every point holds a base value and the step to the next point, and the output is found by linear interpolation between them. The upper bits of a pixel channel pick the segment and the lower bits are the fraction within it.

There are two user tables, A and B. A host loads one of them through a single data port while the other serves pixels, then moves the mode over to the freshly loaded table. The host first clears the load position. It then writes six words per point: the three channel bases first, then the three channel steps. A select bit picks the target table, and a three-bit mask picks which channels really store their words. Besides the two user tables, the mode can select a pass-through, or one of two built-in curves that follow power 2 and power 3 laws. A status output reports which user table is feeding pixels.

Top module: `gamma_pwl_engine`

## Requirements
- R1: While reset is high, and on the first cycle after it, out_valid is 0, every output channel is 0 and status is 0. The load position starts at point 0, word 0.
- R2: Load words are taken in groups of six, in this order: red base, green base, blue base, red step, green step, blue step. The point index advances by one after the sixth word.
- R3: A cycle with wr_idx_clr high returns the load position to point 0, word 0. It takes priority over a word presented in the same cycle, and that word is dropped.
- R4: wr_mask bit 0 gates red, bit 1 gates green and bit 2 gates blue. A masked word is not stored, but it still advances the load position.
- R5: wr_sel 0 writes table A and wr_sel 1 writes table B. The other table is left unchanged.
- R6: mode 0 passes the input through. Mode 1 uses the built-in square curve, with base(i) = floor(i*i*4095/256). Mode 2 uses the built-in cube curve, with base(i) = floor(i*i*i*4095/4096). Modes 3 and 4 use tables A and B. Modes 5 to 7 pass the input through. For the built-in curves, step(i) = base(i+1) - base(i).
- R7: With the default widths, the segment is input bits 11:8 and the fraction is bits 7:0. The result is base + floor(step*fraction/256), saturated at 4095.
- R8: Each pixel presented with pix_valid gives out_valid and its result exactly two clock edges later. Back-to-back pixels are accepted every cycle.
- R9: status is 9 one edge after mode 3 is presented and 10 one edge after mode 4. It is 0 for any other mode.
- R10: Loading the table that is not selected by mode leaves the results of pixels that go through the selected table unchanged.
- R11: After the sixth word of the last point (point 15), the load position wraps to point 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_valid | input | 1 | Pixel present this cycle |
| pix_r | input | 12 | Red input |
| pix_g | input | 12 | Green input |
| pix_b | input | 12 | Blue input |
| mode | input | 3 | Curve selection, sampled with the pixel |
| out_valid | output | 1 | Result present |
| out_r | output | 12 | Red result |
| out_g | output | 12 | Green result |
| out_b | output | 12 | Blue result |
| status | output | 4 | 9 when table A is in use, 10 for table B, else 0 |
| wr_valid | input | 1 | Load word present |
| wr_data | input | 12 | Load word |
| wr_sel | input | 1 | Target table: 0 is A, 1 is B |
| wr_mask | input | 3 | Per-channel store enable |
| wr_idx_clr | input | 1 | Return the load position to point 0, word 0 |

## Verification
A pixel presented at one edge meets the table read on that same edge and is interpolated on the next, so its result is due two edges later. The bench drives on falling edges and samples the outputs on the second falling edge after it drives a pixel. It also checks on the first falling edge that out_valid is still low. status is due one edge after mode changes, so it is sampled on the first falling edge. A load word written at one edge is visible to any pixel sampled at a later edge, and in the streaming test each expected result is compared two cycles after its pixel went in.

// File: rtl/gpl_pkg.sv
package gpl_pkg;

  typedef enum logic [2:0] {
    GM_BYPASS     = 3'd0,
    GM_CURVE_SQ   = 3'd1,
    GM_CURVE_CUBE = 3'd2,
    GM_RAM_A      = 3'd3,
    GM_RAM_B      = 3'd4
  } gm_mode_e;

  localparam logic [3:0] ST_IDLE  = 4'd0;
  localparam logic [3:0] ST_RAM_A = 4'd9;
  localparam logic [3:0] ST_RAM_B = 4'd10;

  localparam int WORDS_PER_POINT = 6;

  // Built-in curve point: kind 0 follows i^2, kind 1 follows i^3.
  function automatic int unsigned gpl_curve_point(input int unsigned kind, input int unsigned idx,
                                                  input int unsigned seg_bits, input int unsigned max_val);
    longint unsigned n, li, p, den;
    n  = 64'd1 << seg_bits;
    li = 64'(idx);
    if (kind == 0) begin
      p   = li * li;
      den = n * n;
    end else begin
      p   = li * li * li;
      den = n * n * n;
    end
    return 32'((p * 64'(max_val)) / den);
  endfunction

  function automatic int unsigned gpl_curve_step(input int unsigned kind, input int unsigned idx,
                                                 input int unsigned seg_bits, input int unsigned max_val);
    return gpl_curve_point(kind, idx + 1, seg_bits, max_val) - gpl_curve_point(kind, idx, seg_bits, max_val);
  endfunction

endpackage

// File: rtl/pwl_table_ram.sv
module pwl_table_ram #(
  parameter int DEPTH = 16,
  parameter int W     = 12,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [DEPTH];

  // Simple dual-port, registered read: maps onto block RAM.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/pwl_write_seq.sv
module pwl_write_seq #(
  parameter int POINTS = 16,
  localparam int AW    = $clog2(POINTS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          wr_valid,
  input  logic [2:0]    wr_mask,
  output logic [AW-1:0] pt_idx,
  output logic [2:0]    we_base,
  output logic [2:0]    we_delta
);

  logic [2:0] phase;

  always_comb begin
    we_base  = '0;
    we_delta = '0;
    if (wr_valid && !clr) begin
      case (phase)
        3'd0: we_base[0]  = wr_mask[0];
        3'd1: we_base[1]  = wr_mask[1];
        3'd2: we_base[2]  = wr_mask[2];
        3'd3: we_delta[0] = wr_mask[0];
        3'd4: we_delta[1] = wr_mask[1];
        3'd5: we_delta[2] = wr_mask[2];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      phase  <= '0;
      pt_idx <= '0;
    end else if (wr_valid) begin
      if (phase == 3'(gpl_pkg::WORDS_PER_POINT - 1)) begin
        phase  <= '0;
        pt_idx <= pt_idx + 1'b1;
      end else begin
        phase <= phase + 1'b1;
      end
    end
  end

  AST_POINT_ADVANCE: assert property (@(posedge clk) disable iff (rst) (wr_valid && !clr && phase == 3'd5) |=> (pt_idx == AW'($past(pt_idx) + 1'b1))); // R2
  AST_CLEAR_RESTART: assert property (@(posedge clk) disable iff (rst) clr |=> (pt_idx == '0 && phase == '0)); // R3
  AST_ONE_WRITE: assert property (@(posedge clk) disable iff (rst) $onehot0({we_base, we_delta})); // R4

endmodule

// File: rtl/pwl_interp.sv
module pwl_interp #(
  parameter int W      = 12,
  parameter int FRAC_W = 8,
  localparam logic [W-1:0] MAXV = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bypass,
  input  logic [W-1:0]      pix,
  input  logic [FRAC_W-1:0] frac,
  input  logic [W-1:0]      base,
  input  logic [W-1:0]      delta,
  output logic [W-1:0]      y
);

  logic [W+FRAC_W-1:0] prod;
  logic [W-1:0]        step;
  logic [W:0]          sum;

  assign prod = (W+FRAC_W)'(delta) * (W+FRAC_W)'(frac);
  assign step = prod[W+FRAC_W-1:FRAC_W];
  assign sum  = {1'b0, base} + {1'b0, step};

  always_ff @(posedge clk) begin
    if (rst)         y <= '0;
    else if (bypass) y <= pix;
    else if (sum[W]) y <= MAXV;
    else             y <= sum[W-1:0];
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) (!bypass && base == MAXV) |=> (y == MAXV)); // R7

endmodule

// File: rtl/gamma_pwl_engine.sv
module gamma_pwl_engine #(
  parameter int IN_W     = 12,
  parameter int SEG_BITS = 4,
  localparam int FRAC_W  = IN_W - SEG_BITS,
  localparam int POINTS  = 1 << SEG_BITS,
  localparam int MAXV    = (1 << IN_W) - 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pix_valid,
  input  logic [IN_W-1:0] pix_r,
  input  logic [IN_W-1:0] pix_g,
  input  logic [IN_W-1:0] pix_b,
  input  logic [2:0]      mode,
  output logic            out_valid,
  output logic [IN_W-1:0] out_r,
  output logic [IN_W-1:0] out_g,
  output logic [IN_W-1:0] out_b,
  output logic [3:0]      status,
  input  logic            wr_valid,
  input  logic [IN_W-1:0] wr_data,
  input  logic            wr_sel,
  input  logic [2:0]      wr_mask,
  input  logic            wr_idx_clr
);
  import gpl_pkg::*;

  logic [SEG_BITS-1:0] pt_idx;
  logic [2:0]          we_base, we_delta;
  logic [IN_W-1:0]     pix_in [3];
  logic [IN_W-1:0]     y      [3];
  logic                s1_valid;
  logic [2:0]          s1_mode;
  logic                s1_bypass;

  assign pix_in[0] = pix_r;
  assign pix_in[1] = pix_g;
  assign pix_in[2] = pix_b;

  pwl_write_seq #(.POINTS(POINTS)) u_wseq (
    .clk(clk), .rst(rst), .clr(wr_idx_clr), .wr_valid(wr_valid), .wr_mask(wr_mask),
    .pt_idx(pt_idx), .we_base(we_base), .we_delta(we_delta)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid  <= 1'b0;
      s1_mode   <= GM_BYPASS;
      out_valid <= 1'b0;
      status    <= ST_IDLE;
    end else begin
      s1_valid  <= pix_valid;
      s1_mode   <= mode;
      out_valid <= s1_valid;
      case (mode)
        GM_RAM_A: status <= ST_RAM_A;
        GM_RAM_B: status <= ST_RAM_B;
        default:  status <= ST_IDLE;
      endcase
    end
  end

  assign s1_bypass = (s1_mode == 3'd0) || (s1_mode > 3'd4);

  for (genvar c = 0; c < 3; c++) begin : g_ch
    logic [SEG_BITS-1:0] seg;
    logic [IN_W-1:0]     rd_base  [2];
    logic [IN_W-1:0]     rd_delta [2];
    logic [IN_W-1:0]     s1_pix, rom_base, rom_delta, sel_base, sel_delta;
    logic [FRAC_W-1:0]   s1_frac;

    assign seg = pix_in[c][IN_W-1 -: SEG_BITS];

    for (genvar r = 0; r < 2; r++) begin : g_ram
      pwl_table_ram #(.DEPTH(POINTS), .W(IN_W)) u_base (
        .clk(clk), .we(we_base[c] && (wr_sel == 1'(r))), .waddr(pt_idx), .wdata(wr_data),
        .raddr(seg), .rdata(rd_base[r])
      );
      pwl_table_ram #(.DEPTH(POINTS), .W(IN_W)) u_delta (
        .clk(clk), .we(we_delta[c] && (wr_sel == 1'(r))), .waddr(pt_idx), .wdata(wr_data),
        .raddr(seg), .rdata(rd_delta[r])
      );
    end

    // Built-in curves: a constant function indexed by the segment, registered like the RAMs.
    always_ff @(posedge clk) begin
      s1_pix    <= pix_in[c];
      s1_frac   <= pix_in[c][FRAC_W-1:0];
      rom_base  <= IN_W'(gpl_curve_point((mode == GM_CURVE_SQ) ? 0 : 1, 32'(seg), SEG_BITS, MAXV));
      rom_delta <= IN_W'(gpl_curve_step((mode == GM_CURVE_SQ) ? 0 : 1, 32'(seg), SEG_BITS, MAXV));
    end

    always_comb begin
      case (s1_mode)
        GM_RAM_A: begin sel_base = rd_base[0]; sel_delta = rd_delta[0]; end
        GM_RAM_B: begin sel_base = rd_base[1]; sel_delta = rd_delta[1]; end
        default:  begin sel_base = rom_base;   sel_delta = rom_delta;   end
      endcase
    end

    pwl_interp #(.W(IN_W), .FRAC_W(FRAC_W)) u_interp (
      .clk(clk), .rst(rst), .bypass(s1_bypass), .pix(s1_pix), .frac(s1_frac),
      .base(sel_base), .delta(sel_delta), .y(y[c])
    );
  end

  assign out_r = y[0];
  assign out_g = y[1];
  assign out_b = y[2];

  AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (rst) (status == ST_IDLE || status == ST_RAM_A || status == ST_RAM_B)); // R9
  AST_STATUS_RAM_A: assert property (@(posedge clk) disable iff (rst) (mode == GM_RAM_A) |=> (status == ST_RAM_A)); // R9
  AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (rst) pix_valid |=> ##1 out_valid); // R8
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst) !pix_valid |=> ##1 !out_valid); // R8

endmodule

// File: tb/sim_gamma_pwl_engine.sv
`timescale 1ns/1ps
module sim_gamma_pwl_engine;

  logic        clk = 1'b0, rst = 1'b1;
  logic        pix_valid = 1'b0;
  logic [11:0] pix_r = '0, pix_g = '0, pix_b = '0;
  logic [2:0]  mode = 3'd0;
  logic        out_valid;
  logic [11:0] out_r, out_g, out_b;
  logic [3:0]  status;
  logic        wr_valid = 1'b0, wr_sel = 1'b0, wr_idx_clr = 1'b0;
  logic [11:0] wr_data = '0;
  logic [2:0]  wr_mask = 3'd7;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;
  int midx = 0, mphase = 0;
  logic [11:0] m_base  [2][3][16];
  logic [11:0] m_delta [2][3][16];
  logic [11:0] sr [10], sg [10], sb [10];

  always #2 clk = ~clk;

  gamma_pwl_engine u0 (
    .clk(clk), .rst(rst), .pix_valid(pix_valid), .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
    .mode(mode), .out_valid(out_valid), .out_r(out_r), .out_g(out_g), .out_b(out_b),
    .status(status), .wr_valid(wr_valid), .wr_data(wr_data), .wr_sel(wr_sel),
    .wr_mask(wr_mask), .wr_idx_clr(wr_idx_clr)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  function automatic int sq_pt(input int i);   return i * i * 4095 / 256;      endfunction
  function automatic int cube_pt(input int i); return i * i * i * 4095 / 4096; endfunction

  function automatic logic [11:0] exp_ch(input logic [2:0] m, input int ch, input logic [11:0] x);
    int seg, fr, b, d, v;
    seg = int'(x[11:8]);
    fr  = int'(x[7:0]);
    case (m)
      3'd1: begin b = sq_pt(seg);   d = sq_pt(seg + 1) - b;   end
      3'd2: begin b = cube_pt(seg); d = cube_pt(seg + 1) - b; end
      3'd3: begin b = int'(m_base[0][ch][seg]); d = int'(m_delta[0][ch][seg]); end
      3'd4: begin b = int'(m_base[1][ch][seg]); d = int'(m_delta[1][ch][seg]); end
      default: return x;
    endcase
    v = b + (d * fr) / 256;
    if (v > 4095) v = 4095;
    return 12'(v);
  endfunction

  function automatic logic [3:0] exp_status(input logic [2:0] m);
    return (m == 3'd3) ? 4'd9 : (m == 3'd4) ? 4'd10 : 4'd0;
  endfunction

  task automatic check_pix(input logic [2:0] m, input logic [11:0] r, input logic [11:0] g,
                           input logic [11:0] b, input string req);
    @(negedge clk);
    mode = m; pix_valid = 1'b1; pix_r = r; pix_g = g; pix_b = b;
    @(negedge clk);
    pix_valid = 1'b0;
    chk("R8 no result after one edge", out_valid, 0);
    chk("R9 status", status, exp_status(m));
    @(negedge clk);
    chk("R8 result after two edges", out_valid, 1);
    chk({req, " red"},   out_r, exp_ch(m, 0, r));
    chk({req, " green"}, out_g, exp_ch(m, 1, g));
    chk({req, " blue"},  out_b, exp_ch(m, 2, b));
  endtask

  // Bench model of the load order from R2, R4, R5, R11.
  task automatic wr_word(input logic [11:0] d, input logic s, input logic [2:0] mk);
    int ch;
    @(negedge clk);
    wr_valid = 1'b1; wr_data = d; wr_sel = s; wr_mask = mk;
    ch = mphase % 3;
    if (mk[ch]) begin
      if (mphase < 3) m_base[s][ch][midx] = d;
      else            m_delta[s][ch][midx] = d;
    end
    mphase++;
    if (mphase == 6) begin mphase = 0; midx = (midx + 1) % 16; end
    @(posedge clk); #1;
    wr_valid = 1'b0;
  endtask

  task automatic clr_idx();
    @(negedge clk);
    wr_idx_clr = 1'b1;
    @(posedge clk); #1;
    wr_idx_clr = 1'b0;
    midx = 0; mphase = 0;
  endtask

  task automatic load_rand(input logic s, input logic [2:0] mk, input int nwords);
    for (int i = 0; i < nwords; i++) wr_word(12'($urandom), s, mk);
  endtask

  task automatic rand_pix(input logic [2:0] m, input int n, input string req);
    for (int i = 0; i < n; i++) check_pix(m, 12'($urandom), 12'($urandom), 12'($urandom), req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    chk("R1 out_valid in reset", out_valid, 0);
    chk("R1 out_r in reset", out_r, 0);
    chk("R1 status in reset", status, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 out_valid after reset", out_valid, 0);
    chk("R1 out_g after reset", out_g, 0);

    // R6: pass-through, including the range ends.
    check_pix(3'd0, 12'd0, 12'd4095, 12'd1234, "R6 bypass");
    rand_pix(3'd0, 3, "R6 bypass");

    // R1 R2 R5: full load of table A from the reset load position.
    load_rand(1'b0, 3'd7, 96);
    check_pix(3'd3, 12'd0, 12'd4095, 12'h0FF, "R2 table A corners");
    rand_pix(3'd3, 20, "R2 table A");

    // R5: table B is loaded separately, and table A is unchanged.
    clr_idx();
    load_rand(1'b1, 3'd7, 96);
    rand_pix(3'd4, 15, "R5 table B");
    rand_pix(3'd3, 5, "R5 table A kept");

    // R4: reload B with green masked off; green keeps its old points.
    clr_idx();
    load_rand(1'b1, 3'b101, 96);
    rand_pix(3'd4, 10, "R4 masked reload");

    // R3: a partial point, then a clear, then a whole point lands on point 0.
    clr_idx();
    load_rand(1'b0, 3'd7, 2);
    clr_idx();
    load_rand(1'b0, 3'd7, 6);
    check_pix(3'd3, 12'h080, 12'h0C0, 12'h0FF, "R3 clear restarts");

    // R11: 17 points in a row, so the last one wraps onto point 0.
    clr_idx();
    load_rand(1'b0, 3'd7, 102);
    check_pix(3'd3, 12'h040, 12'h0A0, 12'h0FE, "R11 wrap to point 0");
    check_pix(3'd3, 12'hF80, 12'hFFF, 12'hF01, "R11 last point intact");

    // R7: saturation on point 0 of table A.
    clr_idx();
    for (int i = 0; i < 3; i++) wr_word(12'd4000, 1'b0, 3'd7);
    for (int i = 0; i < 3; i++) wr_word(12'd4095, 1'b0, 3'd7);
    check_pix(3'd3, 12'h0FF, 12'h000, 12'h080, "R7 interpolation");
    chk("R7 saturated red", out_r, 4095);

    // R6: built-in curves and the spare mode codes.
    check_pix(3'd1, 12'd4095, 12'd0, 12'h7FF, "R6 square curve ends");
    rand_pix(3'd1, 8, "R6 square curve");
    check_pix(3'd2, 12'd4095, 12'd0, 12'h7FF, "R6 cube curve ends");
    rand_pix(3'd2, 8, "R6 cube curve");
    for (int m = 5; m < 8; m++) check_pix(3'(m), 12'($urandom), 12'($urandom), 12'($urandom), "R6 spare mode bypass");

    // R10: table B reloads while table A serves pixels.
    clr_idx();
    fork
      load_rand(1'b1, 3'd7, 96);
      rand_pix(3'd3, 30, "R10 active table during reload");
    join
    rand_pix(3'd4, 6, "R10 reloaded table");

    // R8: back-to-back pixels through table A.
    mode = 3'd3;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (k >= 2) begin
        chk("R8 stream valid", out_valid, 1);
        chk("R8 stream red", out_r, exp_ch(3'd3, 0, sr[k-2]));
        chk("R8 stream blue", out_b, exp_ch(3'd3, 2, sb[k-2]));
      end
      sr[k] = 12'($urandom); sg[k] = 12'($urandom); sb[k] = 12'($urandom);
      pix_r = sr[k]; pix_g = sg[k]; pix_b = sb[k]; pix_valid = 1'b1;
    end
    @(negedge clk);
    pix_valid = 1'b0;
    chk("R8 stream red tail", out_r, exp_ch(3'd3, 0, sr[8]));
    chk("R8 stream green tail", out_g, exp_ch(3'd3, 1, sg[8]));
    @(negedge clk);
    chk("R8 stream green last", out_g, exp_ch(3'd3, 1, sg[9]));
    @(negedge clk);
    chk("R8 stream drains", out_valid, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule